// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a NOR-style flash device. It watches each write cycle, which carries an address and a data byte, and checks that the cycle belongs to a valid command sequence. Every sequence starts with two unlock cycles. Each unlock cycle carries a fixed address/data pair. The third cycle names the operation.

A program takes four cycles. The fourth cycle carries the target address and data. An erase takes six cycles. After the erase setup code, the unlock pair is repeated and a confirm cycle follows. The confirm cycle selects a single block or the whole chip. When a sequence completes, the block raises a one-cycle request, with the captured address and data, to a program/erase controller. A busy/done handshake stands in for that controller.

The block also selects what a read returns: array data, signature data, or operation status. Three kinds of write drop the interface back to array read: any malformed write, a power-fail indication, and a write that breaks an open sequence. A running block erase can be suspended and later resumed. While it is suspended, other blocks can be read or programmed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset is released, `rd_mode_o` is 0 (array), `suspended_o` is 0 and no request output is high.
- R2: A write is an unlock cycle only when bits [10:0] of the address and the data match the pair for its position. The first pair is 0x555/0xAA and the second is 0x2AA/0x55. Address bits above bit 10 are ignored. A first write that does not match is rejected and `rd_mode_o` becomes 0.
- R3: Two unlock cycles, then data 0xA0, then any fourth write, give `prog_req_o`. It is high for exactly one cycle, in the cycle after the fourth write. With it, `op_addr_o` and `op_data_o` carry that write's address and data, and `rd_mode_o` becomes 2 (status).
- R4: Two unlock cycles, 0x80, two unlock cycles, then a sixth write with data 0x30, give `erase_req_o` for one cycle with `erase_chip_o` = 0. `op_addr_o` carries the sixth write's address. `rd_mode_o` becomes 2.
- R5: The same six-write sequence ending with data 0x10 at an address whose bits [10:0] are 0x555 gives `erase_req_o` with `erase_chip_o` = 1. Data 0x10 at any other address aborts the sequence.
- R6: A write that does not fit the open sequence returns the sequencer to its start and sets `rd_mode_o` to 0. The cycles that would have followed it then produce no request.
- R7: Data 0x90 in the third cycle sets `rd_mode_o` to 1 (signature). It stays 1 through valid unlock cycles. It returns to 0 on a rejected write, such as 0xF0 or any other code that is not unlock.
- R8: While `busy_i` is high, every write is ignored, except the suspend write of R9. A complete sequence written during busy produces no request and leaves `rd_mode_o` unchanged.
- R9: A single write of data 0xB0, at any address, suspends a running block erase. It pulses `susp_req_o`, sets `suspended_o` and makes `rd_mode_o` 0. During a program or a chip erase the same write is ignored.
- R10: A single write of data 0x30 while suspended and not busy pulses `resume_req_o`, clears `suspended_o` and makes `rd_mode_o` 2.
- R11: While suspended, a full program sequence is accepted. The erase setup code 0x80 in the third cycle is rejected instead, and that rejected write sets `rd_mode_o` to 0.
- R12: A `done_i` pulse ends the running program, otherwise the running chip erase, otherwise the running, non-suspended block erase. Afterwards `rd_mode_o` is 0 unless another operation is still running.
- R13: `pwr_fail_i` high at a clock edge clears the sequence, all running operations and the suspend flag. On the following cycle `rd_mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_fail_i | input | 1 | Supply-lockout indication, synchronous clear |
| wr_i | input | 1 | One-cycle write strobe |
| addr_i | input | ADDR_W | Latched write address |
| data_i | input | DATA_W | Latched write data |
| busy_i | input | 1 | Controller is executing an operation |
| done_i | input | 1 | Controller finished the current operation |
| prog_req_o | output | 1 | Program request pulse |
| erase_req_o | output | 1 | Erase request pulse |
| erase_chip_o | output | 1 | Erase request targets the whole chip |
| susp_req_o | output | 1 | Erase suspend request pulse |
| resume_req_o | output | 1 | Erase resume request pulse |
| op_addr_o | output | ADDR_W | Address captured with the last request |
| op_data_o | output | DATA_W | Data captured with the last program request |
| suspended_o | output | 1 | A block erase is suspended |
| rd_mode_o | output | 2 | Read source: 0 array, 1 signature, 2 status |

## Verification
The assertions assume the controller behaves:
- `busy_i` is high only while an operation requested by this block is running.
- `busy_i` drops during a suspend.
- `done_i` never arrives in the same cycle as a suspend write.

The bench's controller stub enforces this by design. It derives `busy_i` from the operations it has seen requested, and it issues `done_i` only in cycles without a write. The random stimulus mixes complete and corrupted sequences, with unlock address bits above bit 10 randomised. After each round it ends every open operation, resuming first if needed, so the assumed handshake always holds.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_PROG      = 8'hA0;
  localparam logic [7:0] CMD_ERASE     = 8'h80;
  localparam logic [7:0] CMD_AUTOSEL   = 8'h90;
  localparam logic [7:0] CMD_BLK_CONF  = 8'h30;
  localparam logic [7:0] CMD_CHIP_CONF = 8'h10;
  localparam logic [7:0] CMD_SUSP      = 8'hB0;
  localparam logic [7:0] CMD_RESUME    = 8'h30;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_UNL2,
    SEQ_CMD,
    SEQ_PROG,
    SEQ_EUNL1,
    SEQ_EUNL2,
    SEQ_CONF
  } seq_st_e;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_SIGN   = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;

  typedef struct packed {
    logic prog;
    logic blk;
    logic chip;
    logic sign;
    logic abort;
    logic susp;
    logic resume;
  } seq_ev_t;

endpackage

// File: rtl/flash_code_match.sv
module flash_code_match #(
  parameter int                 CMP_W      = 11,
  parameter int                 DATA_W     = 8,
  parameter logic [CMP_W-1:0]   MATCH_ADDR = '0,
  parameter logic [DATA_W-1:0]  MATCH_DATA = '0
) (
  input  logic [CMP_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              hit_o
);

  assign hit_o = (addr_i == MATCH_ADDR) && (data_i == MATCH_DATA);

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      wr_i,
  input  logic [7:0] cmd_i,
  input  logic [2:0] hit_i,       // [0] unlock A, [1] unlock B, [2] chip confirm
  input  logic      busy_i,
  input  logic      can_susp_i,
  input  logic      suspended_i,
  output seq_ev_t   ev_o,
  output seq_st_e   st_o
);

  seq_st_e st_q, st_d;
  seq_ev_t ev;

  always_comb begin
    ev   = '0;
    st_d = st_q;
    if (wr_i && !clr_i) begin
      if (st_q == SEQ_IDLE && cmd_i == CMD_SUSP && can_susp_i) begin
        ev.susp = 1'b1;
      end else if (!busy_i) begin
        if (st_q == SEQ_IDLE && cmd_i == CMD_RESUME && suspended_i) begin
          ev.resume = 1'b1;
        end else begin
          unique case (st_q)
            SEQ_IDLE:  if (hit_i[0]) st_d = SEQ_UNL2;  else ev.abort = 1'b1;
            SEQ_UNL2:  if (hit_i[1]) st_d = SEQ_CMD;   else ev.abort = 1'b1;
            SEQ_CMD: begin
              if (cmd_i == CMD_PROG) st_d = SEQ_PROG;
              else if (cmd_i == CMD_ERASE && !suspended_i) st_d = SEQ_EUNL1;
              else if (cmd_i == CMD_AUTOSEL) begin
                ev.sign = 1'b1;
                st_d    = SEQ_IDLE;
              end else ev.abort = 1'b1;
            end
            SEQ_PROG: begin
              ev.prog = 1'b1;
              st_d    = SEQ_IDLE;
            end
            SEQ_EUNL1: if (hit_i[0]) st_d = SEQ_EUNL2; else ev.abort = 1'b1;
            SEQ_EUNL2: if (hit_i[1]) st_d = SEQ_CONF;  else ev.abort = 1'b1;
            SEQ_CONF: begin
              st_d = SEQ_IDLE;
              if (cmd_i == CMD_BLK_CONF) ev.blk = 1'b1;
              else if (hit_i[2])         ev.chip = 1'b1;
              else                       ev.abort = 1'b1;
            end
            default: ev.abort = 1'b1;
          endcase
          if (ev.abort) st_d = SEQ_IDLE;
        end
      end
    end
    if (clr_i) st_d = SEQ_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assign ev_o = ev;
  assign st_o = st_q;

  // R2
  first_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEQ_IDLE && wr_i && !busy_i && !hit_i[0] && !clr_i) |=> st_q == SEQ_IDLE);

endmodule

// File: rtl/flash_op_track.sv
module flash_op_track
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  seq_ev_t           ev_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              prog_req_o,
  output logic              erase_req_o,
  output logic              erase_chip_o,
  output logic              susp_req_o,
  output logic              resume_req_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              suspended_o,
  output logic              can_susp_o,
  output rd_mode_e          rd_mode_o
);

  logic prog_act_q, blk_act_q, chip_act_q, susp_q, sign_q;
  logic running;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_act_q   <= 1'b0;
      blk_act_q    <= 1'b0;
      chip_act_q   <= 1'b0;
      susp_q       <= 1'b0;
      sign_q       <= 1'b0;
      prog_req_o   <= 1'b0;
      erase_req_o  <= 1'b0;
      erase_chip_o <= 1'b0;
      susp_req_o   <= 1'b0;
      resume_req_o <= 1'b0;
      op_addr_o    <= '0;
      op_data_o    <= '0;
    end else if (clr_i) begin
      prog_act_q   <= 1'b0;
      blk_act_q    <= 1'b0;
      chip_act_q   <= 1'b0;
      susp_q       <= 1'b0;
      sign_q       <= 1'b0;
      prog_req_o   <= 1'b0;
      erase_req_o  <= 1'b0;
      susp_req_o   <= 1'b0;
      resume_req_o <= 1'b0;
    end else begin
      prog_req_o   <= ev_i.prog;
      erase_req_o  <= ev_i.blk | ev_i.chip;
      susp_req_o   <= ev_i.susp & ~done_i;
      resume_req_o <= ev_i.resume;
      if (done_i) begin
        sign_q <= 1'b0;
        if (prog_act_q)                 prog_act_q <= 1'b0;
        else if (chip_act_q)            chip_act_q <= 1'b0;
        else if (blk_act_q && !susp_q)  blk_act_q  <= 1'b0;
      end
      if (ev_i.prog) begin
        prog_act_q <= 1'b1;
        op_addr_o  <= addr_i;
        op_data_o  <= data_i;
        sign_q     <= 1'b0;
      end
      if (ev_i.blk || ev_i.chip) begin
        blk_act_q    <= ev_i.blk;
        chip_act_q   <= ev_i.chip;
        erase_chip_o <= ev_i.chip;
        op_addr_o    <= addr_i;
        sign_q       <= 1'b0;
      end
      if (ev_i.susp && !done_i) begin
        susp_q <= 1'b1;
        sign_q <= 1'b0;
      end
      if (ev_i.resume) begin
        susp_q <= 1'b0;
        sign_q <= 1'b0;
      end
      if (ev_i.sign)  sign_q <= 1'b1;
      if (ev_i.abort) sign_q <= 1'b0;
    end
  end

  assign running     = prog_act_q | chip_act_q | (blk_act_q & ~susp_q);
  assign rd_mode_o   = running ? RD_STATUS : (sign_q ? RD_SIGN : RD_ARRAY);
  assign suspended_o = susp_q;
  assign can_susp_o  = blk_act_q & ~susp_q;

  // R3
  req_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, erase_req_o, susp_req_o, resume_req_o}));

  // R9
  susp_blk_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp_q) |-> (blk_act_q && !chip_act_q));

  // R10
  resume_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_req_o |-> (!susp_q && rd_mode_o == RD_STATUS));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int               ADDR_W        = 16,
  parameter int               DATA_W        = 8,
  parameter int               CMP_W         = 11,
  parameter logic [CMP_W-1:0] UNLOCK_ADDR_A = 11'h555,
  parameter logic [DATA_W-1:0] UNLOCK_DATA_A = 8'hAA,
  parameter logic [CMP_W-1:0] UNLOCK_ADDR_B = 11'h2AA,
  parameter logic [DATA_W-1:0] UNLOCK_DATA_B = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_fail_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              prog_req_o,
  output logic              erase_req_o,
  output logic              erase_chip_o,
  output logic              susp_req_o,
  output logic              resume_req_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              suspended_o,
  output logic [1:0]        rd_mode_o
);

  localparam int N_CODES = 3;
  localparam logic [N_CODES-1:0][CMP_W-1:0] CODE_ADDR =
    {UNLOCK_ADDR_A, UNLOCK_ADDR_B, UNLOCK_ADDR_A};
  localparam logic [N_CODES-1:0][DATA_W-1:0] CODE_DATA =
    {DATA_W'(CMD_CHIP_CONF), UNLOCK_DATA_B, UNLOCK_DATA_A};

  logic [N_CODES-1:0] hit;
  seq_ev_t            ev;
  seq_st_e            seq_st;
  logic               can_susp;
  rd_mode_e           rd_mode;

  for (genvar g = 0; g < N_CODES; g++) begin : g_code
    flash_code_match #(
      .CMP_W     (CMP_W),
      .DATA_W    (DATA_W),
      .MATCH_ADDR(CODE_ADDR[g]),
      .MATCH_DATA(CODE_DATA[g])
    ) u_match (
      .addr_i(addr_i[CMP_W-1:0]),
      .data_i(data_i),
      .hit_o (hit[g])
    );
  end

  flash_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (pwr_fail_i),
    .wr_i       (wr_i),
    .cmd_i      (data_i[7:0]),
    .hit_i      (hit),
    .busy_i     (busy_i),
    .can_susp_i (can_susp),
    .suspended_i(suspended_o),
    .ev_o       (ev),
    .st_o       (seq_st)
  );

  flash_op_track #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (pwr_fail_i),
    .ev_i        (ev),
    .done_i      (done_i),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .prog_req_o  (prog_req_o),
    .erase_req_o (erase_req_o),
    .erase_chip_o(erase_chip_o),
    .susp_req_o  (susp_req_o),
    .resume_req_o(resume_req_o),
    .op_addr_o   (op_addr_o),
    .op_data_o   (op_data_o),
    .suspended_o (suspended_o),
    .can_susp_o  (can_susp),
    .rd_mode_o   (rd_mode)
  );

  assign rd_mode_o = rd_mode;

  // R8
  no_req_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_req_o || erase_req_o) |-> !$past(busy_i));

  // R3
  prog_after_four_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> $past(seq_st == SEQ_PROG));

  // R4
  erase_after_six_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> $past(seq_st == SEQ_CONF));

  // R13
  pwr_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwr_fail_i) |-> (rd_mode_o == 2'd0 && !suspended_o && seq_st == SEQ_IDLE));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr = 1'b0;
  logic        wr = 1'b0;
  logic        done = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        busy;
  logic        prog_req, erase_req, erase_chip, susp_req, resume_req, suspended;
  logic [15:0] op_addr;
  logic [7:0]  op_data;
  logic [1:0]  rd_mode;

  // controller stub / reference model state
  int m_st;
  bit m_prog, m_blk, m_chip, m_susp, m_sig;
  bit e_prog, e_erase, e_chip, e_susp, e_res;
  logic [15:0] e_addr;
  logic [7:0]  e_data;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  assign busy = m_prog | m_chip | (m_blk & ~m_susp);

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pwr), .wr_i(wr),
    .addr_i(addr), .data_i(data), .busy_i(busy), .done_i(done),
    .prog_req_o(prog_req), .erase_req_o(erase_req), .erase_chip_o(erase_chip),
    .susp_req_o(susp_req), .resume_req_o(resume_req), .op_addr_o(op_addr),
    .op_data_o(op_data), .suspended_o(suspended), .rd_mode_o(rd_mode)
  );

  function automatic logic [1:0] exp_mode();
    if (m_prog || m_chip || (m_blk && !m_susp)) return 2'd2;
    return m_sig ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [15:0] rnd16();
    return 16'($urandom);
  endfunction

  function automatic logic [15:0] up(input logic [10:0] low);
    return {5'($urandom), low};
  endfunction

  task automatic clear_exp();
    e_prog = 0; e_erase = 0; e_chip = 0; e_susp = 0; e_res = 0;
  endtask

  task automatic model_abort();
    m_st = 0; m_sig = 0;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    bit h1, h2;
    h1 = (a[10:0] == 11'h555) && (d == 8'hAA);
    h2 = (a[10:0] == 11'h2AA) && (d == 8'h55);
    clear_exp();
    if (m_st == 0 && d == 8'hB0 && m_blk && !m_susp) begin
      m_susp = 1; m_sig = 0; e_susp = 1;
    end else if (busy) begin
      // ignored
    end else if (m_st == 0 && d == 8'h30 && m_susp) begin
      m_susp = 0; m_sig = 0; e_res = 1;
    end else begin
      case (m_st)
        0: if (h1) m_st = 1; else model_abort();
        1: if (h2) m_st = 2; else model_abort();
        2: if (d == 8'hA0) m_st = 3;
           else if (d == 8'h80 && !m_susp) m_st = 4;
           else if (d == 8'h90) begin m_sig = 1; m_st = 0; end
           else model_abort();
        3: begin m_prog = 1; m_sig = 0; m_st = 0; e_prog = 1; e_addr = a; e_data = d; end
        4: if (h1) m_st = 5; else model_abort();
        5: if (h2) m_st = 6; else model_abort();
        6: begin
             m_st = 0;
             if (d == 8'h30) begin m_blk = 1; m_sig = 0; e_erase = 1; e_chip = 0; e_addr = a; end
             else if (d == 8'h10 && a[10:0] == 11'h555) begin
               m_chip = 1; m_sig = 0; e_erase = 1; e_chip = 1; e_addr = a;
             end else model_abort();
           end
        default: model_abort();
      endcase
    end
  endtask

  task automatic check(input string tag);
    bit bad;
    bad = ({prog_req, erase_req, susp_req, resume_req} != {e_prog, e_erase, e_susp, e_res})
       || (rd_mode != exp_mode()) || (suspended != m_susp)
       || ((e_prog || e_erase) && op_addr != e_addr)
       || (e_prog && op_data != e_data)
       || (e_erase && erase_chip != e_chip);
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: req=%b/%b mode=%0d/%0d susp=%b/%b addr=%h/%h data=%h/%h chip=%b/%b",
        tag, {prog_req, erase_req, susp_req, resume_req}, {e_prog, e_erase, e_susp, e_res},
        rd_mode, exp_mode(), suspended, m_susp, op_addr, e_addr, op_data, e_data,
        erase_chip, e_chip);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr_step(input logic [15:0] a, input logic [7:0] d, input string tag);
    wr = 1; addr = a; data = d;
    @(negedge clk);
    model_write(a, d);
    check(tag);
    wr = 0;
  endtask

  task automatic idle_step(input string tag);
    wr = 0;
    @(negedge clk);
    clear_exp();
    check(tag);
  endtask

  task automatic done_step(input string tag);
    done = 1;
    @(negedge clk);
    done = 0;
    m_sig = 0;
    if (m_prog) m_prog = 0;
    else if (m_chip) m_chip = 0;
    else if (m_blk && !m_susp) m_blk = 0;
    clear_exp();
    check(tag);
  endtask

  task automatic pwr_step(input string tag);
    pwr = 1;
    @(negedge clk);
    pwr = 0;
    m_st = 0; m_prog = 0; m_blk = 0; m_chip = 0; m_susp = 0; m_sig = 0;
    clear_exp();
    check(tag);
  endtask

  task automatic head(input string tag);
    wr_step(up(11'h555), 8'hAA, tag);
    wr_step(up(11'h2AA), 8'h55, tag);
  endtask

  task automatic do_prog(input logic [15:0] a, input logic [7:0] d, input string tag);
    head(tag);
    wr_step(rnd16(), 8'hA0, tag);
    wr_step(a, d, tag);
  endtask

  task automatic erase_head(input string tag);
    head(tag);
    wr_step(rnd16(), 8'h80, tag);
    head(tag);
  endtask

  task automatic settle();
    while (m_prog || m_blk || m_chip) begin
      if (m_susp && !m_prog) wr_step(rnd16(), 8'h30, "R10");
      else done_step("R12");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    m_st = 0;
    e_addr = '0; e_data = '0;
    clear_exp();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1");

    // R3 program, pulse width, op capture
    do_prog(16'h1234, 8'h5A, "R3");
    idle_step("R3");
    done_step("R12");

    // R2 low address bits compared; upper bits free
    wr_step(16'h0554, 8'hAA, "R2");
    wr_step(16'h02AA, 8'h55, "R2");
    wr_step(16'h0555, 8'hA0, "R2");
    wr_step(16'h4000, 8'h11, "R2");
    wr_step(16'hF555, 8'hAA, "R2");
    wr_step(16'h0AAA, 8'h55, "R2");

    // R6 wrong command then tail of a program
    head("R6");
    wr_step(16'h0555, 8'h77, "R6");
    wr_step(16'h0555, 8'hA0, "R6");
    wr_step(16'h2222, 8'h33, "R6");
    // R6 broken erase unlock
    head("R6");
    wr_step(16'h0555, 8'h80, "R6");
    wr_step(16'h0555, 8'hAA, "R6");
    wr_step(16'h02AA, 8'hAA, "R6");
    wr_step(16'h8000, 8'h30, "R6");

    // R7 signature mode
    head("R7");
    wr_step(16'h0555, 8'h90, "R7");
    idle_step("R7");
    head("R7");
    wr_step(16'h0100, 8'hF0, "R7");
    head("R7");
    wr_step(16'h0555, 8'h90, "R7");
    wr_step(16'h0000, 8'hF0, "R7");

    // R8 sequence during busy is ignored
    do_prog(16'h0042, 8'h99, "R8");
    do_prog(16'h0043, 8'h98, "R8");
    wr_step(16'h0000, 8'hB0, "R8");
    done_step("R12");

    // R5 chip erase, suspend ignored (R9)
    erase_head("R5");
    wr_step(16'h3555, 8'h10, "R5");
    wr_step(16'h0000, 8'hB0, "R9");
    done_step("R12");
    erase_head("R5");
    wr_step(16'h0554, 8'h10, "R5");

    // R4 block erase, suspend, program in suspend, resume
    erase_head("R4");
    wr_step(16'hC000, 8'h30, "R4");
    wr_step(16'h1000, 8'hB0, "R9");
    do_prog(16'h2468, 8'h0F, "R11");
    wr_step(16'h0000, 8'h30, "R8");
    done_step("R12");
    head("R11");
    wr_step(16'h0555, 8'h80, "R11");
    wr_step(16'h0000, 8'h30, "R10");
    done_step("R12");

    // R13 power fail mid-sequence and during suspended erase
    head("R13");
    pwr_step("R13");
    wr_step(16'h0555, 8'hA0, "R13");
    erase_head("R13");
    wr_step(16'h8000, 8'h30, "R13");
    wr_step(16'h0000, 8'hB0, "R13");
    pwr_step("R13");

    for (int it = 0; it < 300; it++) begin
      int k;
      k = $urandom_range(0, 5);
      case (k)
        0: wr_step(rnd16(), 8'($urandom), "R6");
        1: begin do_prog(rnd16(), 8'($urandom), "R3"); wr_step(rnd16(), 8'($urandom), "R8"); end
        2: begin
             erase_head("R4");
             wr_step(rnd16(), 8'h30, "R4");
             if ($urandom_range(0, 1) == 1) wr_step(rnd16(), 8'hB0, "R9");
             if ($urandom_range(0, 1) == 1) do_prog(rnd16(), 8'($urandom), "R11");
           end
        3: begin erase_head("R5"); wr_step(up(11'h555), 8'h10, "R5"); wr_step(rnd16(), 8'hB0, "R9"); end
        4: begin head("R7"); wr_step(rnd16(), 8'h90, "R7"); wr_step(rnd16(), 8'($urandom), "R7"); end
        default: begin
             wr_step(up(11'h555), 8'hAA, "R6");
             wr_step(rnd16(), 8'($urandom), "R6");
             wr_step(rnd16(), 8'hA0, "R6");
             wr_step(rnd16(), 8'($urandom), "R6");
           end
      endcase
      settle();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule